// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block sends bytes on an asynchronous serial line. The frame format is set by a control word. The word picks the number of data bits (5 to 8), whether a parity bit is sent, even or odd parity, one or two stop bits, a one-entry or a sixteen-entry transmit buffer, and a break request. Software writes the format through a three-word register port. The low and mid words hold a 16-bit divisor value. The block stores and reports that value but does not use it. Writes to the low and mid words wait in shadow registers. All three words take effect together on a high-word write.

Bytes enter through a write port into the transmit buffer. An outside source supplies a pulse once per bit time, and the transmitter moves only on that pulse. A frame is one low start bit, then the data bits with the least significant bit first, then the optional parity bit, then the high stop bits. The line idles high.

The sequencer has seven states:
- IDLE: the line is high. On a tick, a break request moves it to BREAK. Otherwise, if a byte is waiting, it moves to START and pops that byte.
- START: the start bit. On a tick it moves to DATA.
- DATA: the data bits. On the tick for the last data bit it moves to PARITY if parity is on, or to STOP if not.
- PARITY: on a tick it moves to STOP.
- STOP: on the tick for the final stop bit, the decision is the same as in IDLE (BREAK, START, or back to IDLE).
- BREAK: the line is held low. On a tick with break cleared it moves to GAP.
- GAP: the line is high for one bit time. On a tick, the decision is the same as in IDLE.

The data width, parity setting and stop count are latched when a byte is popped, so a frame already on the line keeps its format.

Top module: `uart_frame_tx`

## Requirements
- R1: The high-word bits [6:5] are the data-length code: 0→5, 1→6, 2→7, 3→8 data bits. Data bits are sent least significant first. Written byte bits above the configured length are never sent and do not affect parity.
- R2: A frame is one low start bit, then the data bits, then the optional parity bit, then the stop bits, which are high. Each bit lasts exactly one tick interval. The line idles high.
- R3: With high-word bit [1] (parity enable) clear, no parity bit is sent, and bit [2] has no effect.
- R4: With parity enabled, high-word bit [2] set makes the number of ones over data and parity even. With bit [2] clear, the number is odd.
- R5: High-word bit [3] set sends two stop bits. Clear, it sends one stop bit.
- R6: If a byte is waiting, its start bit begins on the tick that ends the previous final stop bit, with no idle bit in between.
- R7: With high-word bit [4] set, the buffer holds 16 bytes and sends them in write order. `full` rises at 16 entries, and writes while full are dropped.
- R8: With high-word bit [4] clear, the buffer holds one byte. `full` is set while that byte waits, and further writes are dropped.
- R9: Writes to the low word (select 0) or mid word (select 1) leave `baud_div` unchanged. A high-word write (select 2) moves both shadows into `baud_div` as {mid, low}, and a high-word write alone also commits.
- R10: Setting high-word bit [0] (break) lets the current frame finish unchanged. The line is then held low, and queued bytes are neither sent nor lost.
- R11: After break clears, the line is high for at least one bit time before the next start bit.
- R12: `busy` is high while a frame, a break or the post-break high bit is in progress, or while the buffer is not empty.
- R13: After reset, `txd`=1, `busy`=0, `full`=0 and `baud_div`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 2 | Word select: 0 low, 1 mid, 2 high |
| cfg_wdata | input | 8 | Control word data |
| tx_we | input | 1 | Byte write strobe into the transmit buffer |
| tx_wdata | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Transmitter or buffer active |
| full | output | 1 | Buffer cannot accept a byte |
| baud_div | output | 16 | Committed divisor value {mid, low} |

## Verification
The hardest case to reach is break arriving while a character is partway out with a second byte still queued. The bench enables break after the first three bits of a frame are out. It then checks that the rest of that frame is unchanged and that the line stays low with `busy` held. After break clears, it checks that the queued byte follows at least one high bit time later. The frame format is swept over all 32 combinations of data length, parity enable, parity sense and stop count, with expected frames built arithmetically. Bytes in the sweep carry set bits above the configured length.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_GAP
    } tx_state_e;

    // Committed high word: [6:5] length code, [4] buffer mode,
    // [3] two stops, [2] even sense, [1] parity on, [0] break.
    typedef struct packed {
        logic [1:0] wlen;
        logic       fifo_on;
        logic       stop2;
        logic       even;
        logic       par_on;
        logic       brk;
    } line_cfg_t;

    localparam logic [1:0] SEL_LOW  = 2'd0;
    localparam logic [1:0] SEL_MID  = 2'd1;
    localparam logic [1:0] SEL_HIGH = 2'd2;

endpackage

// File: rtl/uart_cfg_stage.sv
module uart_cfg_stage
    import uart_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            sel,
    input  logic [WORD_W-1:0]     wdata,
    output line_cfg_t             cfg,
    output logic [2*WORD_W-1:0]   div
);

    localparam int CFG_W = $bits(line_cfg_t);

    logic [WORD_W-1:0] shadow_lo, shadow_mid;
    logic [WORD_W-1:0] act_lo, act_mid;
    line_cfg_t         act_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_lo  <= '0;
            shadow_mid <= '0;
            act_lo     <= '0;
            act_mid    <= '0;
            act_hi     <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_LOW:  shadow_lo  <= wdata;
                SEL_MID:  shadow_mid <= wdata;
                SEL_HIGH: begin
                    act_lo  <= shadow_lo;
                    act_mid <= shadow_mid;
                    act_hi  <= line_cfg_t'(wdata[CFG_W-1:0]);
                end
                default: ;
            endcase
        end
    end

    assign cfg = act_hi;
    assign div = {act_mid, act_lo};

    // R9: active settings move only on a high-word write
    assert_commit_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_HIGH) |=> $stable({act_lo, act_mid, act_hi}));

endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;
    logic              accept, take;

    assign empty  = (count == '0);
    assign full   = single ? !empty : (count == CW'(DEPTH));
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign rdata  = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= bump(wptr);
            if (take)   rptr <= bump(rptr);
            unique case ({accept, take})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: ;
            endcase
        end
    end

    // R7: the buffer never exceeds its capacity
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7, R8: a write while full leaves occupancy unchanged
    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        wlen,
    input  logic              par_on,
    input  logic              even,
    input  logic              stop2,
    input  logic              brk,
    input  logic              avail,
    input  logic [DATA_W-1:0] rdata,
    output logic              pop,
    output logic              txd,
    output logic              active
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    tx_state_e         state, state_n;
    logic [DATA_W-1:0] shreg, mask;
    logic [CNT_W-1:0]  bitcnt, nbits, nbits_n;
    logic              par_l, stop2_l, pbit, stopcnt;

    assign nbits_n = CNT_W'(5) + CNT_W'(wlen);

    always_comb begin
        for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(nbits_n));
    end

    // next state and pop decision
    always_comb begin
        state_n = state;
        pop     = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: begin
                if (tick) begin
                    if (brk)        state_n = ST_BREAK;
                    else if (avail) begin state_n = ST_START; pop = 1'b1; end
                    else            state_n = ST_IDLE;
                end
            end
            ST_START:  if (tick) state_n = ST_DATA;
            ST_DATA: begin
                if (tick && bitcnt == nbits - CNT_W'(1))
                    state_n = par_l ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (tick) state_n = ST_STOP;
            ST_STOP: begin
                if (tick && (!stop2_l || stopcnt)) begin
                    if (brk)        state_n = ST_BREAK;
                    else if (avail) begin state_n = ST_START; pop = 1'b1; end
                    else            state_n = ST_IDLE;
                end
            end
            ST_BREAK:  if (tick && !brk) state_n = ST_GAP;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bitcnt  <= '0;
            nbits   <= CNT_W'(5);
            par_l   <= 1'b0;
            stop2_l <= 1'b0;
            pbit    <= 1'b0;
            stopcnt <= 1'b0;
        end else if (pop) begin
            shreg   <= rdata;
            bitcnt  <= '0;
            nbits   <= nbits_n;
            par_l   <= par_on;
            stop2_l <= stop2;
            pbit    <= (^(rdata & mask)) ^ ~even;
            stopcnt <= 1'b0;
        end else if (tick) begin
            if (state == ST_DATA) begin
                shreg  <= shreg >> 1;
                bitcnt <= bitcnt + CNT_W'(1);
            end
            if (state == ST_STOP) stopcnt <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = shreg[0];
            ST_PARITY:          txd = pbit;
            default:            txd = 1'b1;
        endcase
    end

    assign active = (state != ST_IDLE);

    // R7: a pop never occurs on an empty buffer
    assert_pop_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> avail);
    // R10: a frame in flight runs to its stop bits even if break arrives
    assert_frame_not_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |=> (state inside {ST_DATA, ST_PARITY, ST_STOP}));
    // R11: no start bit directly follows break
    assert_gap_after_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK) |=> (state != ST_START));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [WORD_W-1:0]   cfg_wdata,
    input  logic                tx_we,
    input  logic [WORD_W-1:0]   tx_wdata,
    input  logic                baud_tick,
    output logic                txd,
    output logic                busy,
    output logic                full,
    output logic [2*WORD_W-1:0] baud_div
);

    line_cfg_t         cfg;
    logic              empty, pop, active;
    logic [WORD_W-1:0] rdata;

    uart_cfg_stage #(.WORD_W(WORD_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .div   (baud_div)
    );

    uart_tx_buffer #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .single (!cfg.fifo_on),
        .push   (tx_we),
        .wdata  (tx_wdata),
        .pop    (pop),
        .rdata  (rdata),
        .empty  (empty),
        .full   (full)
    );

    uart_tx_engine #(.DATA_W(WORD_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .wlen   (cfg.wlen),
        .par_on (cfg.par_on),
        .even   (cfg.even),
        .stop2  (cfg.stop2),
        .brk    (cfg.brk),
        .avail  (!empty),
        .rdata  (rdata),
        .pop    (pop),
        .txd    (txd),
        .active (active)
    );

    assign busy = active || !empty;

    // R12: an idle block holds the line high
    assert_idle_line_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

endmodule

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;

    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0, tx_we = 0, baud_tick = 0;
    logic [1:0]  cfg_sel = 0;
    logic [7:0]  cfg_wdata = 0, tx_wdata = 0;
    logic        txd, busy, full;
    logic [15:0] baud_div;

    int checks = 0, errors = 0;
    bit done = 0;

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tx_we(tx_we), .tx_wdata(tx_wdata),
        .baud_tick(baud_tick), .txd(txd), .busy(busy), .full(full),
        .baud_div(baud_div)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic hi_write(input int wl, input int pen, input int eps, input int st2,
                            input int fifo, input int brk);
        cfg_write(2'd2, 8'((wl << 5) | (fifo << 4) | (st2 << 3) | (eps << 2) | (pen << 1) | brk));
    endtask

    task automatic byte_write(input logic [7:0] d);
        @(negedge clk); tx_we = 1; tx_wdata = d;
        @(negedge clk); tx_we = 0;
    endtask

    task automatic tick_sample(output logic b);
        @(negedge clk); baud_tick = 1;
        @(negedge clk); baud_tick = 0;
        b = txd;
    endtask

    function automatic int build(input logic [7:0] d, input int wl, input int pen,
                                 input int eps, input int st2, output logic [15:0] f);
        int n = 0, ones = 0;
        f = '1;
        f[n] = 1'b0; n++;
        for (int i = 0; i < 5 + wl; i++) begin
            f[n] = d[i]; ones += int'(d[i]); n++;
        end
        if (pen != 0) begin
            f[n] = (eps != 0) ? ((ones % 2) == 1) : ((ones % 2) == 0);
            n++;
        end
        n += (st2 != 0) ? 2 : 1;
        return n;
    endfunction

    task automatic expect_frame(input logic [7:0] d, input int wl, input int pen,
                                input int eps, input int st2, input string req,
                                output int waited);
        logic [15:0] exp, got;
        logic b;
        int len;
        len = build(d, wl, pen, eps, st2, exp);
        got = '1; waited = 0; b = 1;
        while (b == 1'b1 && waited < 8) begin tick_sample(b); waited++; end
        got[0] = b;
        for (int i = 1; i < len; i++) begin tick_sample(b); got[i] = b; end
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w;
        logic b;
        logic [7:0] d;
        logic [15:0] exp, got;
        int len;
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        check(txd == 1'b1, "R13 txd", txd, 1);
        check(busy == 1'b0, "R13 busy", busy, 0);
        check(full == 1'b0, "R13 full", full, 0);
        check(baud_div == 16'h0, "R13 baud_div", baud_div, 0);

        // R9 staged commit
        cfg_write(2'd0, 8'h12);
        cfg_write(2'd1, 8'h34);
        check(baud_div == 16'h0, "R9 shadow held", baud_div, 0);
        hi_write(3, 0, 0, 0, 1, 0);
        check(baud_div == 16'h3412, "R9 commit", baud_div, 16'h3412);
        cfg_write(2'd0, 8'h56);
        check(baud_div == 16'h3412, "R9 low pending", baud_div, 16'h3412);
        hi_write(3, 0, 0, 0, 1, 0);
        check(baud_div == 16'h3456, "R9 low commit", baud_div, 16'h3456);
        hi_write(3, 0, 0, 0, 1, 0);
        check(baud_div == 16'h3456, "R9 high alone", baud_div, 16'h3456);

        // R1 R2 R3 R4 R5 sweep of all formats, bytes with upper bits set
        for (int c = 0; c < 32; c++) begin
            hi_write(c & 3, (c >> 2) & 1, (c >> 3) & 1, (c >> 4) & 1, 1, 0);
            for (int k = 0; k < 3; k++) begin
                d = 8'((c * 53 + k * 91 + 7) | 8'he0);
                byte_write(d);
                check(busy == 1'b1, "R12 busy queued", busy, 1);
                expect_frame(d, c & 3, (c >> 2) & 1, (c >> 3) & 1, (c >> 4) & 1,
                             (((c >> 2) & 1) != 0) ? "R1 R2 R4 R5 frame" : "R1 R2 R3 R5 frame", w);
            end
        end
        tick_sample(b);
        check(b == 1'b1 && busy == 1'b0, "R12 idle after sweep", {busy, b}, 1);

        // R6 back-to-back
        hi_write(2, 1, 1, 0, 1, 0);
        byte_write(8'h11); byte_write(8'h22); byte_write(8'h33);
        expect_frame(8'h11, 2, 1, 1, 0, "R6 first", w);
        expect_frame(8'h22, 2, 1, 1, 0, "R6 second", w);
        check(w == 1, "R6 no gap", w, 1);
        expect_frame(8'h33, 2, 1, 1, 0, "R6 third", w);
        check(w == 1, "R6 no gap", w, 1);
        repeat (2) tick_sample(b);

        // R7 FIFO depth and drop
        hi_write(3, 0, 0, 0, 1, 0);
        for (int i = 0; i < 15; i++) byte_write(8'(i * 17 + 3));
        check(full == 1'b0, "R7 not full at 15", full, 0);
        byte_write(8'(15 * 17 + 3));
        check(full == 1'b1, "R7 full at 16", full, 1);
        byte_write(8'hee);
        for (int i = 0; i < 16; i++) expect_frame(8'(i * 17 + 3), 3, 0, 0, 0, "R7 order", w);
        ok = 1;
        for (int i = 0; i < 4; i++) begin tick_sample(b); if (b != 1'b1) ok = 0; end
        check(ok && busy == 1'b0, "R7 dropped byte not sent", {busy, ok}, 1);

        // R8 single-entry mode
        hi_write(3, 0, 0, 0, 0, 0);
        byte_write(8'h5a);
        check(full == 1'b1, "R8 full at one", full, 1);
        byte_write(8'ha5);
        expect_frame(8'h5a, 3, 0, 0, 0, "R8 held byte", w);
        ok = 1;
        for (int i = 0; i < 4; i++) begin tick_sample(b); if (b != 1'b1) ok = 0; end
        check(ok && busy == 1'b0, "R8 second write dropped", {busy, ok}, 1);

        // R10 R11 break mid-frame with a queued byte
        hi_write(3, 0, 0, 0, 1, 0);
        byte_write(8'hc3); byte_write(8'h3c);
        len = build(8'hc3, 3, 0, 0, 0, exp);
        got = '1; b = 1; w = 0;
        while (b == 1'b1 && w < 8) begin tick_sample(b); w++; end
        got[0] = b;
        for (int i = 1; i < 4; i++) begin tick_sample(b); got[i] = b; end
        hi_write(3, 0, 0, 0, 1, 1);
        for (int i = 4; i < len; i++) begin tick_sample(b); got[i] = b; end
        check(got == exp, "R10 current frame completes", got, exp);
        ok = 1;
        for (int i = 0; i < 6; i++) begin tick_sample(b); if (b != 1'b0) ok = 0; end
        check(ok, "R10 line held low", ok, 1);
        check(busy == 1'b1, "R12 busy in break", busy, 1);
        hi_write(3, 0, 0, 0, 1, 0);
        expect_frame(8'h3c, 3, 0, 0, 0, "R10 queued byte kept", w);
        check(w >= 2, "R11 high bit before start", w, 2);
        tick_sample(b);
        check(busy == 1'b0 && b == 1'b1, "R12 idle after break", {busy, b}, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule